// File: doc/BRIEF.md
# Serial front end for a two-channel 12-bit converter

This block is the digital responder that sits behind the serial port of a two-channel, 12-bit analog-to-digital converter. It watches a chip-select line (active low), a serial clock and a serial data input. Each of these is taken as synchronous to the block's system clock, which oversamples the serial clock. Once a frame has been opened by a chip-select falling edge, the block skips any leading zeros and takes the first high data bit as a start marker. It then captures three header bits: the input mode, the channel or polarity, and a flag that suppresses the reversed-order replay.

While the header is arriving, the block tells a behavioural sample source which input and which mode to use. It also opens a sample window and, when that window closes, issues a one-cycle conversion strobe. At that moment it latches the parallel conversion result. The block then drives a low null bit, the word most-significant bit first, an optional least-significant-first replay, and zeros for as long as clocks keep coming. The data output has its own enable, so the pin floats outside the shifting phase.

Top module: `adc_serial_responder`

## Requirements
- R1: After reset, `sdo_oe`, `sample_win`, `conv_strobe` and `cfg_valid` are all 0.
- R2: If `cs_n` is low when reset is released, no start marker is accepted until `cs_n` has been high for at least one clock and has gone low again.
- R3: With `cs_n` low, the start marker is the first rising `sclk` edge that sees `sdi`=1, and any rising edges with `sdi`=0 before it are ignored.
- R4: The three rising edges after the start marker carry, in this order, the mode bit, the select bit and the order bit. `mode_single` copies the mode bit (1 = single-ended, 0 = pseudo-differential). `chan_odd` copies the select bit: in single-ended mode it is the channel number, and in pseudo-differential mode 1 means channel 1 is the positive input. `cfg_valid` rises on the second rising edge after the start marker.
- R5: `sample_win` rises on the second rising `sclk` edge after the start marker and falls on the falling edge of the third clock after it. `conv_strobe` is high for exactly one system clock at that falling edge.
- R6: `sdo_oe` stays 0 until the falling edge of the third clock after the start marker. On that edge it goes to 1 and `sdo` drives a 0 null bit.
- R7: The next 12 falling `sclk` edges drive bits 11 down to 0 of the result on `sdo`.
- R8: When the order bit is 0, the next 11 falling edges after bit 0 drive bits 1 up to 11, and every later falling edge drives 0.
- R9: When the order bit is 1, every falling edge after bit 0 drives 0.
- R10: The result is latched from `conv_result` when the sample window closes, and later changes of `conv_result` do not alter the bits shifted out in that frame.
- R11: Raising `cs_n` at any point clears `sdo_oe` and `sample_win` and ends the frame, so the next frame needs a new start marker.
- R12: `sdo` changes only in response to a falling `sclk` edge or to `cs_n` going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| conv_result | input | 12 | Parallel conversion result from the sample source |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the data-out pin (0 = high impedance) |
| cfg_valid | output | 1 | Mode and select bits are valid |
| mode_single | output | 1 | 1 = single-ended, 0 = pseudo-differential |
| chan_odd | output | 1 | Channel in single-ended mode, polarity in pseudo-differential mode |
| sample_win | output | 1 | Sample window is open |
| conv_strobe | output | 1 | One-cycle pulse at the close of the sample window |

## Verification
Every output registers the effect of an `sclk` or `cs_n` change on the first system-clock rising edge that sees it, so each result is due exactly one clock after the stimulus. The bench changes serial lines on the falling system-clock edge and reads outputs on the next falling edge, which catches the one-cycle conversion strobe and each new data bit in that single cycle. The expected output bit for each falling `sclk` edge after the null bit is derived from its position and the order bit.

// File: rtl/adc_if_pkg.sv
// Package: shared types for the converter serial responder.
// Assumes nothing beyond being compiled before the modules that use it.
package adc_if_pkg;

    // Header bits captured after the start marker.
    typedef struct packed {
        logic single;    // 1 = single-ended, 0 = pseudo-differential
        logic odd;       // channel number or polarity
        logic msb_only;  // 1 = no reversed-order replay
    } hdr_cfg_t;

endpackage

// File: rtl/adc_if_edge.sv
// Module: turns the oversampled serial clock into one-cycle rise/fall pulses.
// Assumes sclk is synchronous to clk and each level lasts at least one clk.
module adc_if_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Remember the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Edge pulses from current and previous levels.
    always_comb begin
        rise = sclk & ~sclk_q;
        fall = ~sclk & sclk_q;
    end
endmodule

// File: rtl/adc_if_header.sv
// Module: arms on chip-select high, finds the start marker, captures the
// three header bits, and runs the sample window and conversion strobe.
// Assumes inputs synchronous to clk and one rise/fall pulse per sclk edge.
module adc_if_header
    import adc_if_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sdi,
    input  logic     rise,
    input  logic     fall,
    output hdr_cfg_t cfg,
    output logic     cfg_valid,
    output logic     hdr_done,
    output logic     sample_win,
    output logic     conv_strobe
);
    localparam int HDR_BITS = 3;
    localparam int RC_W     = $clog2(HDR_BITS + 1);

    logic            armed;
    logic            started;
    logic [RC_W-1:0] rcnt;

    // Frame header sequencing: arming, start detection, bit capture, window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            started     <= 1'b0;
            rcnt        <= '0;
            cfg         <= '0;
            cfg_valid   <= 1'b0;
            sample_win  <= 1'b0;
            conv_strobe <= 1'b0;
        end else begin
            conv_strobe <= 1'b0;
            if (cs_n) begin
                armed      <= 1'b1;
                started    <= 1'b0;
                rcnt       <= '0;
                cfg_valid  <= 1'b0;
                sample_win <= 1'b0;
            end else if (rise) begin
                if (!started) begin
                    if (armed && sdi) begin
                        started <= 1'b1;
                        rcnt    <= '0;
                    end
                end else if (rcnt < RC_W'(HDR_BITS)) begin
                    rcnt <= rcnt + 1'b1;
                    case (rcnt)
                        RC_W'(0): cfg.single <= sdi;
                        RC_W'(1): begin
                            cfg.odd    <= sdi;
                            cfg_valid  <= 1'b1;
                            sample_win <= 1'b1;
                        end
                        default:  cfg.msb_only <= sdi;
                    endcase
                end
            end else if (fall && sample_win && rcnt == RC_W'(HDR_BITS)) begin
                sample_win  <= 1'b0;
                conv_strobe <= 1'b1;
            end
        end
    end

    // Header complete once the order bit has been captured.
    always_comb hdr_done = started && (rcnt == RC_W'(HDR_BITS));

    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !started);                                    // R2
    AST_WIN_CLOSED_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sample_win);                                   // R11
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);                           // R5
    AST_STROBE_CLOSES_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> !sample_win && $past(sample_win));       // R5
endmodule

// File: rtl/adc_if_shifter.sv
// Module: drives the null bit, the word high bit first, the optional reversed
// replay and then zeros, one bit per falling serial clock edge.
// Assumes hdr_done and cfg are stable for the rest of the frame.
module adc_if_shifter
    import adc_if_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fall,
    input  logic              hdr_done,
    input  hdr_cfg_t          cfg,
    input  logic [DATA_W-1:0] conv_result,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int SLOT_MAX = 2 * DATA_W;
    localparam int CNT_W    = $clog2(SLOT_MAX + 1);

    logic              active;
    logic [CNT_W-1:0]  slot;
    logic [CNT_W-1:0]  slot_nxt;
    logic [DATA_W-1:0] word;
    logic              bit_nxt;

    // Next slot number, saturating in the zero region.
    always_comb slot_nxt = (slot == CNT_W'(SLOT_MAX)) ? slot : slot + 1'b1;

    // Output bit for the next slot: high-first word, optional replay, zeros.
    always_comb begin
        int idx;
        int k;
        k       = int'(slot_nxt);
        idx     = -1;
        bit_nxt = 1'b0;
        if (k >= 1 && k <= DATA_W)
            idx = DATA_W - k;
        else if (!cfg.msb_only && k > DATA_W && k < SLOT_MAX)
            idx = k - DATA_W;
        for (int i = 0; i < DATA_W; i++)
            if (i == idx) bit_nxt = word[i];
    end

    // Shift sequencing on falling serial clock edges; deselect aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slot   <= '0;
            word   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (cs_n) begin
            active <= 1'b0;
            slot   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (fall) begin
            if (!active) begin
                if (hdr_done) begin
                    active <= 1'b1;
                    slot   <= '0;
                    word   <= conv_result;
                    sdo    <= 1'b0;
                    sdo_oe <= 1'b1;
                end
            end else begin
                slot <= slot_nxt;
                sdo  <= bit_nxt;
            end
        end
    end

    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);                                       // R11
    AST_SDO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_n) |=> $stable(sdo));                      // R12
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_n) |=> $stable(word));                    // R10
    AST_NULL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);                                 // R6
endmodule

// File: rtl/adc_serial_responder.sv
// Module: top of the converter serial responder. Joins edge detection,
// header capture and the output shifter.
// Assumes cs_n, sclk and sdi are synchronous to clk and oversampled.
module adc_serial_responder
    import adc_if_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [DATA_W-1:0] conv_result,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              cfg_valid,
    output logic              mode_single,
    output logic              chan_odd,
    output logic              sample_win,
    output logic              conv_strobe
);
    logic     rise;
    logic     fall;
    logic     hdr_done;
    hdr_cfg_t cfg;

    adc_if_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    adc_if_header u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .rise       (rise),
        .fall       (fall),
        .cfg        (cfg),
        .cfg_valid  (cfg_valid),
        .hdr_done   (hdr_done),
        .sample_win (sample_win),
        .conv_strobe(conv_strobe)
    );

    adc_if_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .fall       (fall),
        .hdr_done   (hdr_done),
        .cfg        (cfg),
        .conv_result(conv_result),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    // Export the decoded header bits.
    always_comb begin
        mode_single = cfg.single;
        chan_odd    = cfg.odd;
    end

    AST_OE_NEEDS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sample_win && $past(sample_win));    // R6
endmodule

// File: tb/adc_serial_responder_test.sv
// Bench: table of frames walked by one loop, then directed reset/abort tests.
module adc_serial_responder_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [W-1:0] conv_result = '0;
    logic         sdo, sdo_oe, cfg_valid, mode_single, chan_odd, sample_win, conv_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Vector: {lead zeros[1:0], mode, select, order, result[11:0]}
    localparam logic [16:0] VEC [6] = '{
        {2'd0, 1'b1, 1'b0, 1'b1, 12'hA5C},
        {2'd2, 1'b1, 1'b1, 1'b0, 12'h3C1},
        {2'd1, 1'b0, 1'b0, 1'b0, 12'hFFF},
        {2'd3, 1'b0, 1'b1, 1'b1, 12'h801},
        {2'd0, 1'b1, 1'b0, 1'b0, 12'h001},
        {2'd1, 1'b0, 1'b1, 1'b0, 12'h7E9}
    };

    adc_serial_responder #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .conv_result(conv_result), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_valid(cfg_valid), .mode_single(mode_single), .chan_odd(chan_odd),
        .sample_win(sample_win), .conv_strobe(conv_strobe)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rise(input logic d);
        sclk = 1'b1; sdi = d;
        @(negedge clk);
    endtask

    task automatic fall();
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic deselect();
        cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Expected bit on the k-th falling edge after the null bit.
    function automatic logic exp_bit(input logic [W-1:0] r, input logic order, input int k);
        if (k >= 1 && k <= W) return r[W-k];
        if (!order && k > W && k < 2*W) return r[k-W];
        return 1'b0;
    endfunction

    // Run one complete frame and check every stage of it.
    task automatic frame(input logic [16:0] v);
        logic [1:0]   lead;
        logic         md, sel, ord;
        logic [W-1:0] res;
        int           bad;
        {lead, md, sel, ord, res} = v;
        deselect();
        cs_n = 1'b0; conv_result = res;
        @(negedge clk);
        for (int i = 0; i < int'(lead); i++) begin
            rise(1'b0); fall();
        end
        rise(1'b1);
        check("R3 leading zeros skipped, no window at start", {31'd0, sample_win}, 32'd0);
        fall();
        rise(md);
        check("R5 window not open on first edge", {31'd0, sample_win}, 32'd0);
        fall();
        rise(sel);
        check("R5 window opens on second edge", {31'd0, sample_win}, 32'd1);
        check("R4 config valid and decoded", {29'd0, cfg_valid, mode_single, chan_odd},
              {29'd0, 1'b1, md, sel});
        fall();
        rise(ord);
        check("R6 output disabled before null", {31'd0, sdo_oe}, 32'd0);
        sclk = 1'b0;
        @(negedge clk);
        check("R5 strobe at window close", {30'd0, conv_strobe, sample_win}, 32'b10);
        check("R6 null bit driven low", {30'd0, sdo_oe, sdo}, 32'b10);
        @(negedge clk);
        check("R5 strobe lasts one cycle", {31'd0, conv_strobe}, 32'd0);
        conv_result = ~res;
        bad = 0;
        for (int k = 1; k <= 2*W + 4; k++) begin
            rise(1'b0); fall();
            if (sdo !== exp_bit(res, ord, k)) begin
                bad++;
                $display("FAIL %s slot %0d actual=%0b expected=%0b",
                         (k <= W) ? "R7" : (ord ? "R9" : "R8"), k, sdo, exp_bit(res, ord, k));
            end
        end
        n_chk++;
        if (bad != 0) n_bad++;
        cs_n = 1'b1;
        @(negedge clk);
        check("R11 deselect floats output", {30'd0, sdo_oe, sample_win}, 32'd0);
    endtask

    initial begin
        // R1/R2: reset with chip select already low
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {28'd0, sdo_oe, sample_win, conv_strobe, cfg_valid}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            rise(1'b1); fall();
        end
        check("R2 no start without chip-select edge",
              {29'd0, cfg_valid, sample_win, sdo_oe}, 32'd0);

        foreach (VEC[i]) frame(VEC[i]);

        // R11: abort in the data phase, then a fresh frame needs a new start
        deselect();
        cs_n = 1'b0; conv_result = 12'h5A5;
        @(negedge clk);
        rise(1'b1); fall(); rise(1'b1); fall(); rise(1'b1); fall(); rise(1'b1); fall();
        rise(1'b0); fall(); rise(1'b0); fall();
        check("R11 output enabled mid-frame", {31'd0, sdo_oe}, 32'd1);
        cs_n = 1'b1;
        @(negedge clk);
        check("R11 abort clears enable", {31'd0, sdo_oe}, 32'd0);
        cs_n = 1'b0;
        @(negedge clk);
        rise(1'b0); fall(); rise(1'b0); fall();
        check("R11 no header after abort without start", {30'd0, cfg_valid, sample_win}, 32'd0);
        rise(1'b1); fall(); rise(1'b0); fall(); rise(1'b1);
        check("R11 new start accepted after abort", {30'd0, cfg_valid, chan_odd}, 32'b11);
        fall();
        frame({2'd2, 1'b1, 1'b1, 1'b1, 12'hC3A});

        // R1: reset mid-frame returns to reset state
        deselect();
        cs_n = 1'b0;
        @(negedge clk);
        rise(1'b1); fall(); rise(1'b0); fall(); rise(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset clears window and config", {30'd0, cfg_valid, sample_win}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule